// File: doc/BRIEF.md
# Sensor Register Target on a Two-Wire Serial Bus

This block is the serial-bus target that sits in front of a sensor's register file. It watches the clock and data lines, finds the start, repeated-start and stop conditions, and answers only to its own 7-bit device address. A write transaction loads a register pointer and then stores data bytes. A read transaction sets the pointer, issues a repeated start and then returns data bytes from that pointer. The data line is modelled as a pull-low enable plus a sampled input. The open-drain pad is outside the block.

The register space has two regions. The low region holds the conversion results. The region above it holds configuration bytes, which are presented on a parallel output. While a transaction is open, the controller reads a frozen copy of the results, taken when the transaction began. A conversion that completes during the transaction is parked and raises a pending flag. It is copied into the readable results as soon as the stop condition arrives. The effect is that a multi-byte read never mixes bytes from two different conversions.

Top module: `i2c_lockreg_target`

## Requirements
- R1: After reset, the data-line enable is low, every configuration byte is 0x00 and the pending flag is low.
- R2: A start is recognised only when SDA falls while SCL is high, and a stop only when SDA rises while SCL is high. Address bits clocked in without a preceding start get no acknowledge.
- R3: The first byte after a start carries the 7-bit address in bits 7..1 and the read flag in bit 0 (1 = read). On a match, the target pulls SDA low during the ninth clock. On a mismatch, it never drives SDA until the next start or stop.
- R4: In a write, the first byte after the address loads the pointer. Every later byte is acknowledged, stored at the pointer, and then the pointer advances by one, modulo 256.
- R5: Addresses 0 to NUM_RES-1 are the read-only result bytes, and writes to them are dropped. Addresses NUM_RES to NUM_RES+NUM_CFG-1 are configuration bytes; configuration byte k appears on cfg_o bits 8k+7..8k. Any other address reads 0x00.
- R6: After a repeated start and a read address, bytes are shifted out MSB first from the pointer, and the pointer advances after each byte. A controller ACK (SDA low in the ninth clock) continues the read. A NACK makes the target release SDA until the next start or stop.
- R7: The readable results are frozen at the first start of a transaction and do not change until its stop, including across repeated starts.
- R8: A conversion that completes during a transaction sets the pending flag on the next clock. After the stop, the newest such conversion becomes readable and the flag clears.
- R9: A conversion that completes while the bus is idle becomes readable at once. Result byte i is conv_data_i bits 8i+7..8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| conv_valid_i | input | 1 | One-cycle strobe: a new conversion result is ready |
| conv_data_i | input | 8*NUM_RES | Result bytes of the completed conversion |
| cfg_o | output | 8*NUM_CFG | Configuration bytes as written over the bus |
| upd_pending_o | output | 1 | A conversion is parked until the current stop |

## Verification
Reads are tried from a fresh idle conversion, across the boundary between the result and configuration regions, and from an unmapped address. These separate the pointer stepping from the region decode. Conversions are injected between the pointer byte and the repeated start, and again after it. This shows that the lock is taken once per transaction, that the newest parked value is the one applied, and that the pending flag rises and falls when it should. A foreign address, bits clocked without a start, and bytes clocked after a NACK all test silence on the data line. The configuration output and pending flag are compared against the bench model on every settled clock.

// File: rtl/i2c_lt_pkg.sv
package i2c_lt_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_WRITE,
      ST_READ,
      ST_RACK,
      ST_IGNORE
   } bus_state_t;

endpackage

// File: rtl/i2c_lt_sync.sv
module i2c_lt_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic start_o,
   output logic stop_o,
   output logic scl_rise_o,
   output logic scl_fall_o
);

   if (SYNC_STAGES < 2) begin : g_bad_depth
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
   logic                   scl_p, sda_p;
   logic                   scl_s, sda_s;

   assign scl_s = scl_sh[SYNC_STAGES-1];
   assign sda_s = sda_sh[SYNC_STAGES-1];

   // lines idle high, so reset to ones to avoid a false edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
         scl_p  <= scl_s;
         sda_p  <= sda_s;
      end
   end

   assign sda_o      = sda_s;
   assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
   assign scl_rise_o = scl_s & ~scl_p;
   assign scl_fall_o = ~scl_s & scl_p;

endmodule

// File: rtl/i2c_lt_engine.sv
module i2c_lt_engine
   import i2c_lt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h35
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start_i,
   input  logic  stop_i,
   input  logic  scl_rise_i,
   input  logic  scl_fall_i,
   input  logic  sda_i,
   input  byte_t rd_data_i,
   output byte_t ptr_o,
   output logic  wr_en_o,
   output byte_t wr_addr_o,
   output byte_t wr_data_o,
   output logic  sda_oe_o
);

   bus_state_t st_q;
   logic [2:0] bcnt_q;
   logic [6:0] sh_q;
   logic       oe_q, rw_q, first_q, half_q, acked_q, wr_en_q;
   byte_t      ptr_q, wr_addr_q, wr_data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         bcnt_q    <= '0;
         sh_q      <= '0;
         oe_q      <= 1'b0;
         rw_q      <= 1'b0;
         first_q   <= 1'b0;
         half_q    <= 1'b0;
         acked_q   <= 1'b0;
         wr_en_q   <= 1'b0;
         ptr_q     <= '0;
         wr_addr_q <= '0;
         wr_data_q <= '0;
      end else begin
         wr_en_q <= 1'b0;
         if (stop_i) begin
            st_q <= ST_IDLE;
            oe_q <= 1'b0;
         end else if (start_i) begin
            st_q    <= ST_ADDR;
            oe_q    <= 1'b0;
            bcnt_q  <= '0;
            first_q <= 1'b1;
         end else begin
            unique case (st_q)
               ST_ADDR: if (scl_rise_i) begin
                  sh_q <= {sh_q[5:0], sda_i};
                  if (bcnt_q == 3'd7) begin
                     bcnt_q <= '0;
                     if (sh_q == DEV_ADDR) begin
                        st_q   <= ST_ACK;
                        rw_q   <= sda_i;
                        half_q <= 1'b0;
                     end else begin
                        st_q <= ST_IGNORE;
                     end
                  end else begin
                     bcnt_q <= bcnt_q + 3'd1;
                  end
               end
               // first falling edge: pull low; second: release and move on
               ST_ACK: if (scl_fall_i) begin
                  if (!half_q) begin
                     oe_q   <= 1'b1;
                     half_q <= 1'b1;
                  end else begin
                     half_q <= 1'b0;
                     bcnt_q <= '0;
                     if (rw_q) begin
                        st_q <= ST_READ;
                        sh_q <= rd_data_i[6:0];
                        oe_q <= ~rd_data_i[7];
                     end else begin
                        st_q <= ST_WRITE;
                        oe_q <= 1'b0;
                     end
                  end
               end
               ST_WRITE: if (scl_rise_i) begin
                  sh_q <= {sh_q[5:0], sda_i};
                  if (bcnt_q == 3'd7) begin
                     bcnt_q <= '0;
                     st_q   <= ST_ACK;
                     half_q <= 1'b0;
                     if (first_q) begin
                        ptr_q   <= {sh_q, sda_i};
                        first_q <= 1'b0;
                     end else begin
                        wr_en_q   <= 1'b1;
                        wr_addr_q <= ptr_q;
                        wr_data_q <= {sh_q, sda_i};
                        ptr_q     <= ptr_q + 8'd1;
                     end
                  end else begin
                     bcnt_q <= bcnt_q + 3'd1;
                  end
               end
               ST_READ: begin
                  if (scl_rise_i) begin
                     bcnt_q <= bcnt_q + 3'd1;
                     if (bcnt_q == 3'd7) begin
                        ptr_q  <= ptr_q + 8'd1;
                        st_q   <= ST_RACK;
                        half_q <= 1'b0;
                     end
                  end else if (scl_fall_i) begin
                     oe_q <= ~sh_q[6];
                     sh_q <= {sh_q[5:0], 1'b0};
                  end
               end
               ST_RACK: begin
                  if (scl_fall_i) begin
                     if (!half_q) begin
                        oe_q <= 1'b0;
                     end else if (acked_q) begin
                        st_q   <= ST_READ;
                        bcnt_q <= '0;
                        sh_q   <= rd_data_i[6:0];
                        oe_q   <= ~rd_data_i[7];
                     end else begin
                        st_q <= ST_IGNORE;
                        oe_q <= 1'b0;
                     end
                  end else if (scl_rise_i) begin
                     acked_q <= ~sda_i;
                     half_q  <= 1'b1;
                  end
               end
               ST_IDLE, ST_IGNORE: ;
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign ptr_o     = ptr_q;
   assign wr_en_o   = wr_en_q;
   assign wr_addr_o = wr_addr_q;
   assign wr_data_o = wr_data_q;
   assign sda_oe_o  = oe_q;

   // R3
   ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IGNORE) |-> !oe_q);

   // R2
   start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !stop_i) |=> (st_q == ST_ADDR && !oe_q && first_q));

   // R6
   nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RACK && half_q && !acked_q && scl_fall_i && !start_i && !stop_i)
      |=> (st_q == ST_IGNORE && !oe_q));

   // R4
   write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_q |-> (ptr_q == wr_addr_q + 8'd1));

endmodule

// File: rtl/i2c_lt_regfile.sv
module i2c_lt_regfile
   import i2c_lt_pkg::*;
#(
   parameter int unsigned NUM_RES = 4,
   parameter int unsigned NUM_CFG = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic                        stop_i,
   input  logic                        conv_valid_i,
   input  logic [BYTE_W*NUM_RES-1:0]   conv_data_i,
   input  logic                        wr_en_i,
   input  byte_t                       wr_addr_i,
   input  byte_t                       wr_data_i,
   input  byte_t                       rd_addr_i,
   output byte_t                       rd_data_o,
   output logic [BYTE_W*NUM_CFG-1:0]   cfg_o,
   output logic                        pend_o
);

   localparam int unsigned RES_W = BYTE_W * NUM_RES;
   localparam int unsigned CFG_W = BYTE_W * NUM_CFG;

   logic [RES_W-1:0] shadow_q, held_q;
   logic [CFG_W-1:0] cfg_w;
   logic             busy_q, pend_q;

   // frozen copy: follows conversions only while no transaction is open
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         pend_q   <= 1'b0;
         shadow_q <= '0;
         held_q   <= '0;
      end else if (stop_i) begin
         busy_q <= 1'b0;
         pend_q <= 1'b0;
         if (conv_valid_i)
            shadow_q <= conv_data_i;
         else if (pend_q)
            shadow_q <= held_q;
      end else begin
         if (start_i)
            busy_q <= 1'b1;
         if (conv_valid_i) begin
            if (busy_q) begin
               held_q <= conv_data_i;
               pend_q <= 1'b1;
            end else begin
               shadow_q <= conv_data_i;
            end
         end
      end
   end

   for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
      localparam int unsigned SLOT = NUM_RES + g;
      byte_t byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q <= '0;
         else if (wr_en_i && wr_addr_i == 8'(SLOT))
            byte_q <= wr_data_i;
      end
      assign cfg_w[BYTE_W*g +: BYTE_W] = byte_q;
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < NUM_RES; i++)
         if (rd_addr_i == 8'(i)) rd_data_o = shadow_q[BYTE_W*i +: BYTE_W];
      for (int j = 0; j < NUM_CFG; j++)
         if (rd_addr_i == 8'(NUM_RES + j)) rd_data_o = cfg_w[BYTE_W*j +: BYTE_W];
   end

   assign cfg_o  = cfg_w;
   assign pend_o = pend_q;

   // R7
   snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !stop_i) |=> $stable(shadow_q));

   // R8
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && conv_valid_i && !stop_i) |=> pend_q);

   // R8
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> !pend_q);

   // R9
   idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && conv_valid_i && !stop_i) |=> (shadow_q == $past(conv_data_i)));

endmodule

// File: rtl/i2c_lockreg_target.sv
module i2c_lockreg_target
   import i2c_lt_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h35,
   parameter int unsigned NUM_RES     = 4,
   parameter int unsigned NUM_CFG     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      scl_i,
   input  logic                      sda_i,
   output logic                      sda_oe_o,
   input  logic                      conv_valid_i,
   input  logic [8*NUM_RES-1:0]      conv_data_i,
   output logic [8*NUM_CFG-1:0]      cfg_o,
   output logic                      upd_pending_o
);

   localparam int unsigned MAP_SIZE = NUM_RES + NUM_CFG;

   if (NUM_RES < 1 || NUM_CFG < 1 || MAP_SIZE > 256) begin : g_bad_map
      $error("register map must hold 1..256 bytes with both regions present");
   end

   logic  sda_s, start_w, stop_w, rise_w, fall_w, wr_en_w;
   byte_t ptr_w, rd_data_w, wr_addr_w, wr_data_w;

   i2c_lt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .sda_o      (sda_s),
      .start_o    (start_w),
      .stop_o     (stop_w),
      .scl_rise_o (rise_w),
      .scl_fall_o (fall_w)
   );

   i2c_lt_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_w),
      .stop_i     (stop_w),
      .scl_rise_i (rise_w),
      .scl_fall_i (fall_w),
      .sda_i      (sda_s),
      .rd_data_i  (rd_data_w),
      .ptr_o      (ptr_w),
      .wr_en_o    (wr_en_w),
      .wr_addr_o  (wr_addr_w),
      .wr_data_o  (wr_data_w),
      .sda_oe_o   (sda_oe_o)
   );

   i2c_lt_regfile #(.NUM_RES(NUM_RES), .NUM_CFG(NUM_CFG)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_w),
      .stop_i       (stop_w),
      .conv_valid_i (conv_valid_i),
      .conv_data_i  (conv_data_i),
      .wr_en_i      (wr_en_w),
      .wr_addr_i    (wr_addr_w),
      .wr_data_i    (wr_data_w),
      .rd_addr_i    (ptr_w),
      .rd_data_o    (rd_data_w),
      .cfg_o        (cfg_o),
      .pend_o       (upd_pending_o)
   );

endmodule

// File: tb/i2c_lockreg_target_bench.sv
module i2c_lockreg_target_bench;

   localparam int         NR  = 4;
   localparam int         NC  = 4;
   localparam logic [6:0] DEV = 7'h35;
   localparam int         Q   = 10;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe, sda_bus, pend;
   logic conv_v = 1'b0;
   logic [8*NR-1:0] conv_d = '0;
   logic [8*NC-1:0] cfg;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_lockreg_target #(.DEV_ADDR(DEV), .NUM_RES(NR), .NUM_CFG(NC)) u_i2c_lockreg_target (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl_m),
      .sda_i         (sda_bus),
      .sda_oe_o      (sda_oe),
      .conv_valid_i  (conv_v),
      .conv_data_i   (conv_d),
      .cfg_o         (cfg),
      .upd_pending_o (pend)
   );

   int n_tests = 0, n_fail = 0;
   int quiet_hits = 0, mon_err = 0;
   logic [7:0] m_latest [NR];
   logic [7:0] m_shadow [NR];
   logic [7:0] m_cfg    [NC];
   int m_ptr = 0;
   bit m_first = 0, m_txn = 0, m_pend = 0, settled = 0, quiet = 0;

   function automatic logic [8*NC-1:0] m_cfg_vec();
      logic [8*NC-1:0] v;
      for (int k = 0; k < NC; k++) v[8*k +: 8] = m_cfg[k];
      return v;
   endfunction

   function automatic logic [7:0] m_read(int p);
      if (p < NR) return m_shadow[p];
      if (p < NR + NC) return m_cfg[p - NR];
      return 8'h00;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // per-clock comparison of outputs against the model, away from the edge
   always @(posedge clk) begin
      #1;
      if (quiet && sda_oe) quiet_hits++;
      if (settled && (cfg !== m_cfg_vec() || pend !== m_pend)) begin
         if (mon_err == 0)
            $display("mismatch at %0t: cfg %h/%h pend %b/%b", $time, cfg, m_cfg_vec(), pend, m_pend);
         mon_err++;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      settled = 0;
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
      m_txn = 1; m_first = 1;
      settled = 1;
   endtask

   task automatic bus_rstart();
      settled = 0;
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
      m_first = 1;
      settled = 1;
   endtask

   task automatic bus_stop();
      settled = 0;
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(2*Q);
      m_txn = 0;
      if (m_pend) begin
         for (int k = 0; k < NR; k++) m_shadow[k] = m_latest[k];
         m_pend = 0;
      end
      settled = 1;
   endtask

   task automatic bit_out(logic b);
      sda_m = b; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bit_in(output logic b);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b = sda_bus; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(logic [7:0] b, bit to_us, output bit ack);
      logic x;
      settled = 0;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(x);
      ack = !x;
      if (to_us) begin
         if (m_first) m_ptr = b;
         else begin
            if (m_ptr >= NR && m_ptr < NR + NC) m_cfg[m_ptr - NR] = b;
            m_ptr = (m_ptr + 1) % 256;
         end
         m_first = 0;
      end
      settled = 1;
   endtask

   task automatic recv_byte(bit give_ack, string req);
      logic [7:0] got, exp;
      logic x;
      exp = m_read(m_ptr);
      m_ptr = (m_ptr + 1) % 256;
      for (int i = 7; i >= 0; i--) begin
         bit_in(x);
         got[i] = x;
      end
      bit_out(!give_ack);
      check(req, 32'(got), 32'(exp));
   endtask

   task automatic pulse_conv(logic [8*NR-1:0] d);
      settled = 0;
      @(negedge clk);
      conv_d = d; conv_v = 1'b1;
      for (int k = 0; k < NR; k++) m_latest[k] = d[8*k +: 8];
      if (m_txn) m_pend = 1;
      else for (int k = 0; k < NR; k++) m_shadow[k] = m_latest[k];
      @(negedge clk);
      conv_v = 1'b0;
      @(negedge clk);
      settled = 1;
   endtask

   task automatic read_seq(int p, int n, string req);
      bit ack;
      bus_start();
      send_byte({DEV, 1'b0}, 0, ack);
      check("R3 address ack", 32'(ack), 32'd1);
      send_byte(8'(p), 1, ack);
      bus_rstart();
      send_byte({DEV, 1'b1}, 0, ack);
      check("R6 read address ack", 32'(ack), 32'd1);
      for (int i = 0; i < n; i++) recv_byte(i < n - 1, req);
      bus_stop();
   endtask

   task automatic write_seq(int p, logic [7:0] d0, logic [7:0] d1, int n);
      bit ack;
      bus_start();
      send_byte({DEV, 1'b0}, 0, ack);
      check("R3 address ack", 32'(ack), 32'd1);
      send_byte(8'(p), 1, ack);
      check("R4 pointer ack", 32'(ack), 32'd1);
      send_byte(d0, 1, ack);
      check("R4 data ack", 32'(ack), 32'd1);
      if (n > 1) begin
         send_byte(d1, 1, ack);
         check("R4 data ack", 32'(ack), 32'd1);
      end
      bus_stop();
   endtask

   initial begin
      bit ack;
      for (int k = 0; k < NR; k++) begin m_latest[k] = '0; m_shadow[k] = '0; end
      for (int k = 0; k < NC; k++) m_cfg[k] = '0;
      tick(10);
      rst_n = 1'b1;
      tick(5);
      // R1 reset state
      check("R1 sda enable", 32'(sda_oe), 32'd0);
      check("R1 cfg", 32'(cfg), 32'd0);
      check("R1 pending", 32'(pend), 32'd0);
      settled = 1;

      // R4 write two configuration bytes with pointer auto-increment
      write_seq(NR, 8'hA5, 8'h3C, 2);
      check("R4 cfg after write", 32'(cfg), 32'h00003CA5);

      // R9 conversion while idle is readable; R6 MSB-first multi-byte read
      pulse_conv(32'h44332211);
      read_seq(0, 4, "R9 idle result read");

      // R5 write to result region dropped, region crossing, unmapped read
      write_seq(1, 8'hEE, 8'h00, 1);
      read_seq(1, 1, "R5 result read-only");
      read_seq(3, 3, "R6 read across regions");
      write_seq(NR + NC, 8'h77, 8'h00, 1);
      read_seq(NR + NC, 1, "R5 unmapped reads zero");
      check("R5 cfg unchanged", 32'(cfg), 32'h00003CA5);

      // R7 lock across repeated start; R8 deferred update
      bus_start();
      send_byte({DEV, 1'b0}, 0, ack);
      send_byte(8'h00, 1, ack);
      pulse_conv(32'h88776655);
      check("R8 pending set", 32'(pend), 32'd1);
      bus_rstart();
      pulse_conv(32'hCCBBAA99);
      send_byte({DEV, 1'b1}, 0, ack);
      for (int i = 0; i < 4; i++) recv_byte(i < 3, "R7 frozen result");
      check("R8 pending still set", 32'(pend), 32'd1);
      bus_stop();
      check("R8 pending cleared", 32'(pend), 32'd0);
      read_seq(0, 4, "R8 newest applied after stop");

      // R3 foreign address: no acknowledge, no drive, no write
      quiet = 1;
      bus_start();
      send_byte({7'h12, 1'b0}, 0, ack);
      check("R3 mismatch no ack", 32'(ack), 32'd0);
      send_byte(8'h04, 0, ack);
      send_byte(8'h5A, 0, ack);
      bus_stop();
      quiet = 0;
      check("R3 cfg untouched", 32'(cfg), 32'h00003CA5);

      // R6 NACK releases the line
      bus_start();
      send_byte({DEV, 1'b0}, 0, ack);
      send_byte(8'(NR), 1, ack);
      bus_rstart();
      send_byte({DEV, 1'b1}, 0, ack);
      recv_byte(0, "R6 single byte then NACK");
      quiet = 1;
      begin
         logic [7:0] got;
         logic x;
         for (int i = 7; i >= 0; i--) begin bit_in(x); got[i] = x; end
         check("R6 silent after NACK", 32'(got), 32'hFF);
      end
      bus_stop();
      quiet = 0;

      // R2 address clocked without a start is not acknowledged
      settled = 0;
      scl_m = 1'b0; tick(Q);
      send_byte({DEV, 1'b0}, 0, ack);
      check("R2 no start no ack", 32'(ack), 32'd0);
      bus_stop();

      check("R3 R6 line silent when required", 32'(quiet_hits), 32'd0);
      check("R4 R8 per-clock model compare", 32'(mon_err), 32'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule